// File: doc/BRIEF.md
# Equivalent-Time Waveform Capture

This block is a diagnostic capture engine for one CCD video channel. It works on the raw ADC sample stream, with no differential averaging. It rebuilds the pixel waveform at a time resolution finer than the ADC sample period. Each ADC sample period is split into `NPH` sub-sample delay steps, 10 by default. The block tells the analog timing logic which step to use through `phase_o`. It moves to the next step after a programmable number of pixels. The intended input is dark pixels, so the waveform repeats from one pixel to the next apart from noise.

Inside every pixel, the block first sums a window of post-reset samples. The window length is a power of two, so the mean is a right shift of the sum. The block subtracts that mean from each following sample, which removes the reset (kTC) offset of that pixel. It then writes the signed result into a buffer. Sample `k` taken under step `p` goes to address `k*NPH+p`, so a plain linear readout returns the waveform in time order. One of `NCH` lanes is chosen by a channel register. Changing that register aborts a capture. When the last step completes, the block raises `done`, and the buffer is read through a registered address/data port.

Top module: `etc_capture`

## Requirements
- R1: After reset, `busy` and `done` are 0, `phase_o` is 0 and the channel register holds 0.
- R2: A pulse on `arm` sets `busy`, clears `done`, sets `phase_o` to 0 and latches `arm_ppp`. Capture begins at the next sample that is marked with `pix_start`. Samples that arrive before that mark are not stored.
- R3: A pixel begins with a valid sample marked `pix_start`, which is sample 0. Its first 2^`REF_LOG2` samples form the reference window. Every later stored value equals the raw code minus floor(window sum / 2^`REF_LOG2`), written as a signed `DW+1`-bit number.
- R4: The k-th sample after the reference window (k = 0 .. `NSMP`-1), taken while `phase_o` = p, is written to buffer address k*`NPH`+p.
- R5: `phase_o` advances by one after every `arm_ppp` completed pixels. An `arm_ppp` value of 0 is treated as 1.
- R6: When the last pixel of step `NPH`-1 completes, `done` goes to 1, `busy` goes to 0 and `phase_o` returns to 0. Later pixels write nothing.
- R7: Only the selected lane is captured. Lane c occupies bits [c*`DW` +: `DW`] of `smp_bus`, and the lane is chosen by the channel register, which is written with `chan_we`/`chan_wdata`.
- R8: A channel write with a value different from the one held clears `busy` and `done` and stops all buffer writes. A write of the value already held has no effect.
- R9: While `smp_vld` is low, input is ignored, including `pix_start`. Samples after index 2^`REF_LOG2`+`NSMP`-1 of a pixel are also ignored.
- R10: A new `pix_start` before a pixel completes restarts the pixel. The pixel count and `phase_o` do not advance.
- R11: `rd_data` shows the buffer word at `rd_addr` one clock after the address is presented.
- R12: When `arm_ppp` > 1, each address holds the value from the last pixel of that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | A raw sample is present on every lane |
| smp_bus | input | NCH*DW | Unsigned raw ADC codes, one lane per channel |
| pix_start | input | 1 | Marks the current valid sample as sample 0 of a pixel |
| chan_we | input | 1 | Write strobe for the channel register |
| chan_wdata | input | CHW | New channel number |
| arm | input | 1 | Start a capture run |
| arm_ppp | input | PPW | Pixels per delay step, latched on `arm` |
| phase_o | output | PW | Current sub-sample delay step |
| busy | output | 1 | Capture run in progress |
| done | output | 1 | All delay steps captured |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | DW+1 | Signed buffer word, one cycle after `rd_addr` |

## Verification
The reference samples are built so that the window sum leaves a remainder, which shows whether the mean is truncated. The signal samples contain the pixel seed with a different weight from the one in the reference samples, so each stored value identifies both its step and the pixel it came from. The lanes differ by a per-lane slope, so a wrong lane selection moves every stored value. Three runs are made. One uses two pixels per step, a restarted pixel and a masked `pix_start`. One is aborted by a channel change after a write of the same channel. One uses a zero `arm_ppp` on another lane. Between these, the full buffer is read back in address order.

// File: rtl/etc_pkg.sv
package etc_pkg;
   // width of an index for v items, never below one bit
   function automatic int idx_w(input int v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction
endpackage

// File: rtl/etc_lane_sel.sv
module etc_lane_sel #(
   parameter int NCH = 4,
   parameter int DW  = 16,
   parameter int CHW = 2
) (
   input  logic [NCH*DW-1:0] bus_i,
   input  logic [CHW-1:0]    sel_i,
   output logic [DW-1:0]     lane_o
);
   localparam int NSLOT = 1 << CHW;
   logic [DW-1:0] slot [NSLOT];

   generate
      for (genvar i = 0; i < NSLOT; i++) begin : g_slot
         if (i < NCH) begin : g_real
            assign slot[i] = bus_i[i*DW +: DW];
         end else begin : g_pad
            assign slot[i] = '0;
         end
      end
   endgenerate

   assign lane_o = slot[sel_i];
endmodule

// File: rtl/etc_ref_mean.sv
module etc_ref_mean #(
   parameter int DW       = 16,
   parameter int REF_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              acc_i,
   input  logic [DW-1:0]     raw_i,
   output logic signed [DW:0] diff_o
);
   localparam int SW = DW + REF_LOG2;
   logic [SW-1:0] sum_q;
   logic [DW-1:0] mean;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_q <= '0;
      else if (clr_i) sum_q <= SW'(raw_i);
      else if (acc_i) sum_q <= sum_q + SW'(raw_i);
   end

   // power-of-two window: the divide is a plain bit slice
   assign mean   = sum_q[SW-1:REF_LOG2];
   assign diff_o = $signed({1'b0, raw_i}) - $signed({1'b0, mean});

   p_acc_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_i && acc_i));
endmodule

// File: rtl/etc_seq.sv
module etc_seq
   import etc_pkg::*;
#(
   parameter int REF_LOG2 = 2,
   parameter int NSMP     = 16,
   parameter int NPH      = 10,
   parameter int PPW      = 8,
   parameter int CHW      = 2,
   parameter int AW       = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_vld,
   input  logic           pix_start,
   input  logic           chan_we,
   input  logic [CHW-1:0] chan_wdata,
   input  logic           arm,
   input  logic [PPW-1:0] arm_ppp,
   output logic [CHW-1:0] chan_o,
   output logic [idx_w(NPH)-1:0] phase_o,
   output logic           busy,
   output logic           done,
   output logic           acc_clr,
   output logic           acc_en,
   output logic           wr_en,
   output logic [AW-1:0]  wr_addr
);
   localparam int REF  = 1 << REF_LOG2;
   localparam int LAST = REF + NSMP - 1;
   localparam int CW   = $clog2(LAST + 1);
   localparam int PW   = idx_w(NPH);

   logic [CW-1:0]  cnt_q;
   logic           in_pix_q, busy_q, done_q;
   logic [PPW-1:0] ppp_q, pix_q;
   logic [PW-1:0]  ph_q;
   logic [CHW-1:0] chan_q;
   logic           take, chan_chg, pix_end, grp_end, ph_end;
   logic [CW-1:0]  k;

   assign take     = busy_q && smp_vld;
   assign chan_chg = chan_we && (chan_wdata != chan_q);
   assign acc_clr  = take && pix_start;
   assign acc_en   = take && !pix_start && in_pix_q && (cnt_q <  CW'(REF));
   assign wr_en    = take && !pix_start && in_pix_q && (cnt_q >= CW'(REF));
   assign pix_end  = wr_en && (cnt_q == CW'(LAST));
   assign grp_end  = (ppp_q == '0) || (pix_q == ppp_q - PPW'(1));
   assign ph_end   = (ph_q == PW'(NPH - 1));
   assign k        = cnt_q - CW'(REF);
   assign wr_addr  = AW'(k) * AW'(NPH) + AW'(ph_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0; in_pix_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
         ppp_q <= '0; pix_q <= '0; ph_q <= '0; chan_q <= '0;
      end else begin
         if (chan_we) chan_q <= chan_wdata;
         if (chan_chg) begin
            busy_q <= 1'b0; done_q <= 1'b0; in_pix_q <= 1'b0;
            ph_q <= '0; pix_q <= '0;
         end else if (arm) begin
            busy_q <= 1'b1; done_q <= 1'b0; in_pix_q <= 1'b0;
            ph_q <= '0; pix_q <= '0; ppp_q <= arm_ppp;
         end else if (take) begin
            if (pix_start) begin
               in_pix_q <= 1'b1;
               cnt_q    <= CW'(1);
            end else if (in_pix_q) begin
               if (pix_end) begin
                  in_pix_q <= 1'b0;
                  if (grp_end) begin
                     pix_q <= '0;
                     if (ph_end) begin
                        ph_q <= '0; busy_q <= 1'b0; done_q <= 1'b1;
                     end else begin
                        ph_q <= ph_q + PW'(1);
                     end
                  end else begin
                     pix_q <= pix_q + PPW'(1);
                  end
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
         end
      end
   end

   assign chan_o  = chan_q;
   assign phase_o = ph_q;
   assign busy    = busy_q;
   assign done    = done_q;

   p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q < PW'(NPH));
   p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !arm && !chan_chg) |=>
      (ph_q == $past(ph_q) || ph_q == $past(ph_q) + PW'(1) || ph_q == '0));
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);
   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chan_chg |=> (!busy_q && !done_q));
   p_write_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (busy_q && smp_vld));
   p_pix_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && ppp_q != '0) |-> (pix_q < ppp_q));
endmodule

// File: rtl/etc_buf.sv
module etc_buf #(
   parameter int DEPTH = 160,
   parameter int AW    = 8,
   parameter int WW    = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [WW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [WW-1:0] rdata
);
   logic [WW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= (raddr < AW'(DEPTH)) ? mem[raddr] : '0;
   end

   p_waddr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (waddr < AW'(DEPTH)));
endmodule

// File: rtl/etc_capture.sv
module etc_capture
   import etc_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int DW       = 16,
   parameter int REF_LOG2 = 2,
   parameter int NSMP     = 16,
   parameter int NPH      = 10,
   parameter int PPW      = 8,
   localparam int CHW     = idx_w(NCH),
   localparam int PW      = idx_w(NPH),
   localparam int DEPTH   = NSMP * NPH,
   localparam int AW      = idx_w(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [NCH*DW-1:0] smp_bus,
   input  logic              pix_start,
   input  logic              chan_we,
   input  logic [CHW-1:0]    chan_wdata,
   input  logic              arm,
   input  logic [PPW-1:0]    arm_ppp,
   output logic [PW-1:0]     phase_o,
   output logic              busy,
   output logic              done,
   input  logic [AW-1:0]     rd_addr,
   output logic [DW:0]       rd_data
);
   generate
      if (NCH < 1 || DW < 2 || NSMP < 1 || NPH < 2 || PPW < 1 || REF_LOG2 < 0)
         begin : g_bad_cfg
         $error("etc_capture: parameter out of range");
      end
   endgenerate

   logic [CHW-1:0]   chan;
   logic [DW-1:0]    lane;
   logic             acc_clr, acc_en, wr_en;
   logic [AW-1:0]    wr_addr;
   logic signed [DW:0] diff;

   etc_lane_sel #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_sel (
      .bus_i(smp_bus), .sel_i(chan), .lane_o(lane));

   etc_seq #(.REF_LOG2(REF_LOG2), .NSMP(NSMP), .NPH(NPH), .PPW(PPW),
             .CHW(CHW), .AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .pix_start(pix_start),
      .chan_we(chan_we), .chan_wdata(chan_wdata), .arm(arm), .arm_ppp(arm_ppp),
      .chan_o(chan), .phase_o(phase_o), .busy(busy), .done(done),
      .acc_clr(acc_clr), .acc_en(acc_en), .wr_en(wr_en), .wr_addr(wr_addr));

   etc_ref_mean #(.DW(DW), .REF_LOG2(REF_LOG2)) u_mean (
      .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .acc_i(acc_en),
      .raw_i(lane), .diff_o(diff));

   etc_buf #(.DEPTH(DEPTH), .AW(AW), .WW(DW + 1)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(diff),
      .raddr(rd_addr), .rdata(rd_data));
endmodule

// File: tb/tb_etc_capture.sv
module tb_etc_capture;
   logic clk = 0;
   always #2.5 clk = ~clk;

   logic        rst_n, smp_vld, pix_start, chan_we, arm;
   logic [63:0] smp_bus;
   logic [1:0]  chan_wdata;
   logic [7:0]  arm_ppp, rd_addr;
   logic [3:0]  phase_o;
   logic        busy, done;
   logic [16:0] rd_data;

   etc_capture dut (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_bus(smp_bus),
      .pix_start(pix_start), .chan_we(chan_we), .chan_wdata(chan_wdata), .arm(arm),
      .arm_ppp(arm_ppp), .phase_o(phase_o), .busy(busy), .done(done),
      .rd_addr(rd_addr), .rd_data(rd_data));

   int errors = 0, checks = 0;
   int exp_mem [160];
   bit cap; int ph, pip, pppe, sel;
   int q_addr [$]; int q_val [$];
   logic rd_req = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rawv(input int c, input int kind, input int j, input int s);
      if (kind == 0) return 1000 + 100*c + s + ((j == 3) ? 4 : j); // window sum remainder 3
      if (kind == 1) return 900 + 130*c + 2*s + 37*j;
      return 5000 + 11*c + j;
   endfunction

   task automatic samp(input bit ps, input int kind, input int j, input int s);
      smp_vld = 1; pix_start = ps;
      for (int c = 0; c < 4; c++) smp_bus[c*16 +: 16] = 16'(rawv(c, kind, j, s));
      @(negedge clk);
      smp_vld = 0; pix_start = 0;
   endtask

   task automatic pixel(input int s, input bit partial);
      samp(1, 0, 0, s);
      for (int j = 1; j < 4; j++) samp(0, 0, j, s);
      pix_start = 1; @(negedge clk); pix_start = 0;   // R9 masked mark
      for (int k = 0; k < (partial ? 2 : 16); k++) samp(0, 1, k, s);
      if (!partial) begin
         samp(0, 2, 0, s); samp(0, 2, 1, s);          // R9 tail samples
         if (cap) begin
            for (int k = 0; k < 16; k++) exp_mem[k*10 + ph] = 30*sel + s - 101 + 37*k;
            pip++;
            if (pip >= pppe) begin
               pip = 0;
               if (ph == 9) begin cap = 0; ph = 0; end else ph++;
            end
         end
      end
   endtask

   task automatic do_arm(input int v);
      arm = 1; arm_ppp = 8'(v); @(negedge clk); arm = 0;
      cap = 1; ph = 0; pip = 0; pppe = (v == 0) ? 1 : v;
   endtask

   task automatic set_chan(input int v);
      chan_we = 1; chan_wdata = 2'(v); @(negedge clk); chan_we = 0;
      if (v != sel) begin cap = 0; ph = 0; pip = 0; end
      sel = v;
   endtask

   task automatic readout();
      for (int a = 0; a < 160; a++) begin
         rd_addr = 8'(a); rd_req = 1;
         q_addr.push_back(a); q_val.push_back(exp_mem[a]);
         @(negedge clk);
      end
      rd_req = 0;
      repeat (2) @(negedge clk);
   endtask

   // monitor: compares each registered read against the scoreboard
   always @(posedge clk) begin
      if (rd_req) begin
         int a, e;
         #1;
         a = q_addr.pop_front(); e = q_val.pop_front();
         checks++;
         if (int'($signed(rd_data)) != e) begin
            errors++;
            $display("FAIL R3/R4/R7/R11/R12 addr %0d: actual=%0d expected=%0d",
                     a, int'($signed(rd_data)), e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 0; smp_vld = 0; pix_start = 0; chan_we = 0; arm = 0;
      smp_bus = '0; chan_wdata = '0; arm_ppp = '0; rd_addr = '0;
      cap = 0; ph = 0; pip = 0; pppe = 1; sel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1; @(negedge clk);
      chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 phase", phase_o, 0);

      // run A: lane 2, two pixels per step, one restarted pixel
      set_chan(2);
      do_arm(2);
      chk("R2 busy", busy, 1); chk("R2 done", done, 0); chk("R2 phase", phase_o, 0);
      for (int n = 0; n < 20; n++) begin
         chk("R5 phase before pixel", phase_o, ph);
         if (n == 6) begin
            pixel(500, 1);                               // R10 partial pixel
            chk("R10 phase unchanged", phase_o, ph);
         end
         pixel(10 + 3*n, 0);
      end
      chk("R6 done", done, 1); chk("R6 busy", busy, 0); chk("R6 phase", phase_o, 0);
      pixel(700, 0);                                     // R6 ignored after done
      chk("R6 done held", done, 1);
      readout();

      // run B: same-value channel write, then an aborting change
      do_arm(1);
      pixel(200, 0); pixel(230, 0);
      chk("R5 phase after two pixels", phase_o, 2);
      set_chan(2);
      chk("R8 same value keeps busy", busy, 1);
      set_chan(1);
      chk("R8 abort busy", busy, 0); chk("R8 abort done", done, 0);
      pixel(260, 0);                                     // R8 no writes after abort
      readout();

      // run C: lane 1, arm_ppp 0 treated as 1, stray samples before first mark
      do_arm(0);
      chk("R2 phase cleared", phase_o, 0);
      for (int j = 0; j < 3; j++) samp(0, 1, j, 77);     // R2 ignored
      for (int n = 0; n < 10; n++) begin
         chk("R5 one pixel per step", phase_o, n);
         pixel(40 + 7*n, 0);
      end
      chk("R6 done run C", done, 1); chk("R6 busy run C", busy, 0);
      readout();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule